// File: doc/BRIEF.md
# ADC Auto-Trigger Start Controller

This block decides when an analog-to-digital conversion begins and keeps the finished result for a byte-wide register interface. A 4-bit select code picks one of sixteen trigger settings. Three codes follow pulse-type synchronization lines that carry no flag. Ten codes follow flag-type lines, which start a conversion on their rising edge. One code runs the converter continuously, and two codes are reserved. A software start works at all times. The select code only matters while auto-trigger is enabled.

The block sends a one-cycle start pulse to an abstract converter. It gets back a busy level and a done pulse that carries a 10-bit result. The result appears as a low byte and a high byte. Reading the low byte locks both bytes until the high byte is read, so the two halves always belong to one conversion. A result that finishes during the lock waits in a one-entry pending buffer.

Top module: `adc_trig_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both result bytes, the lock, the pending buffer and the edge-detect registers. After reset `conv_start` is low.
- R2: The select code map is: 0 to 2 are synchronization lines, 3 to 12 are flag lines, 13 is free-running, and 14 and 15 are reserved. A reserved code never starts a conversion. Line `trig_lines[k]` belongs to code k.
- R3: While `auto_en` is low, the trigger lines and the select code have no effect. A `sw_start` sampled while the converter is idle starts a conversion in either mode.
- R4: In auto mode a flag code starts a conversion when its line is seen rising. `conv_start` is high in the cycle after the clock edge that first samples the line high.
- R5: A flag line that is already high when `auto_en` rises, or when the select code moves to it, does not start a conversion.
- R6: A flag rising edge that arrives while `conv_busy` is high is dropped. It does not start a conversion later.
- R7: In auto mode a synchronization code starts a conversion in every cycle in which its line is high and the converter is idle. A line that is high while `conv_busy` is high starts nothing.
- R8: In auto mode with code 13, a conversion starts on the first clock edge at which the converter is idle. This includes the edge right after `conv_busy` falls.
- R9: `conv_start` is never high for two cycles in a row. It is never high in the cycle after a cycle with `conv_busy` high.
- R10: A `conv_done` pulse while the registers are unlocked loads the result. From the next cycle `res_lo` is result bits 7:0, and `res_hi` holds result bits 9:8 in its bits 1:0 with zeros above.
- R11: A `rd_lo` pulse locks the result bytes. From the cycle of that read until the lock is released by `rd_hi`, no completion changes `res_lo` or `res_hi`.
- R12: A completion during the lock is kept as pending, and a later one replaces it. The pending value reaches the result bytes on the clock edge after the `rd_hi` cycle, so it is visible two cycles after `rd_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Auto-trigger enable |
| trig_sel | input | 4 | Trigger select code |
| trig_lines | input | 16 | Trigger source lines, bit k for code k |
| sw_start | input | 1 | Software conversion start |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_busy | input | 1 | Converter busy |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 10 | Conversion result |
| rd_lo | input | 1 | Low result byte read strobe |
| rd_hi | input | 1 | High result byte read strobe |
| res_lo | output | 8 | Low result byte |
| res_hi | output | 8 | High result byte, zero-extended |

## Verification
A start decision is registered once, so `conv_start` is checked one clock edge after the inputs that cause it. A result load is also checked one edge after `conv_done`. Release of a pending result is checked two edges after `rd_hi`, and the bench confirms that the bytes have not changed at the first of those two edges. Inputs change on the falling edge and outputs are read on the next falling edge, so each check reads exactly one rising edge's effect. Checks for dropped events read `conv_start` for several cycles after the stimulus, to show that nothing was queued.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SEL_W  = 4;
    localparam int NSRC   = 1 << SEL_W;
    localparam int RES_W  = 10;
    localparam int BYTE_W = 8;

    localparam logic [SEL_W-1:0] SYNC_LAST  = 4'd2;
    localparam logic [SEL_W-1:0] FLAG_LAST  = 4'd12;
    localparam logic [SEL_W-1:0] FREE_CODE  = 4'd13;

    typedef enum logic [1:0] {
        K_SYNC,
        K_FLAG,
        K_FREE,
        K_NONE
    } src_kind_e;

    function automatic src_kind_e kind_of(input logic [SEL_W-1:0] code);
        if (code <= SYNC_LAST)      return K_SYNC;
        else if (code <= FLAG_LAST) return K_FLAG;
        else if (code == FREE_CODE) return K_FREE;
        else                        return K_NONE;
    endfunction

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lines;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lines[i] & ~st_q.prev[i];
    end
endmodule

// File: rtl/adc_trig_start.sv
module adc_trig_start
    import adc_trig_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            auto_en,
    input  logic [SEL_W-1:0] sel,
    input  logic            sw_start,
    input  logic            conv_busy,
    input  logic [NSRC-1:0] lines,
    input  logic [NSRC-1:0] rise,
    output logic            conv_start
);
    typedef struct packed {
        logic start;
    } start_st_t;

    start_st_t st_d, st_q;
    logic      idle;
    logic      hit;

    always_comb begin
        st_d = st_q;
        idle = !conv_busy && !st_q.start;
        unique case (kind_of(sel))
            K_SYNC:  hit = lines[sel];
            K_FLAG:  hit = rise[sel];
            K_FREE:  hit = 1'b1;
            default: hit = 1'b0;
        endcase
        st_d.start = idle && (sw_start || (auto_en && hit));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign conv_start = st_q.start;
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic [RES_W-1:0] result,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic [BYTE_W-1:0] res_hi,
    output logic             locked
);
    localparam int HI_W = RES_W - BYTE_W;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [RES_W-1:0] pend;
        logic             pend_v;
        logic             lock;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     block;

    always_comb begin
        st_d  = st_q;
        block = st_q.lock | rd_lo;

        if (rd_hi)      st_d.lock = 1'b0;
        else if (rd_lo) st_d.lock = 1'b1;

        if (done && !block) begin
            st_d.data   = result;
            st_d.pend_v = 1'b0;
        end else if (done) begin
            st_d.pend   = result;
            st_d.pend_v = 1'b1;
        end else if (st_q.pend_v && !block) begin
            st_d.data   = st_q.pend;
            st_d.pend_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign res_lo = st_q.data[BYTE_W-1:0];
    assign res_hi = BYTE_W'(st_q.data[RES_W-1:BYTE_W]);
    assign locked = st_q.lock;

    if (HI_W < 1 || HI_W > BYTE_W) begin : g_bad_width
        initial $display("adc_result_lock: RES_W out of range");
    end
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int RW = RES_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [NSRC-1:0]   trig_lines,
    input  logic              sw_start,
    output logic              conv_start,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [RW-1:0]     conv_result,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic [BYTE_W-1:0] res_hi
);
    logic [NSRC-1:0] rise;
    logic            res_locked;

    adc_trig_edge #(.N(NSRC)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lines (trig_lines),
        .rise  (rise)
    );

    adc_trig_start u_start (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .sel        (trig_sel),
        .sw_start   (sw_start),
        .conv_busy  (conv_busy),
        .lines      (trig_lines),
        .rise       (rise),
        .conv_start (conv_start)
    );

    adc_result_lock #(.RES_W(RW), .BYTE_W(BYTE_W)) u_res (
        .clk    (clk),
        .rst    (rst),
        .done   (conv_done),
        .result (conv_result),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .res_lo (res_lo),
        .res_hi (res_hi),
        .locked (res_locked)
    );
endmodule

// File: rtl/adc_trig_checker.sv
module adc_trig_checker #(
    parameter int RW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          auto_en,
    input logic          sw_start,
    input logic [3:0]    trig_sel,
    input logic          conv_busy,
    input logic          conv_done,
    input logic [RW-1:0] conv_result,
    input logic          rd_lo,
    input logic          rd_hi,
    input logic          conv_start,
    input logic [7:0]    res_lo,
    input logic [7:0]    res_hi,
    input logic          locked
);
    a_r9_one_wide: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    a_r9_none_after_busy: assert property (@(posedge clk) disable iff (rst)
        conv_busy |=> !conv_start);

    a_r3_manual_only: assert property (@(posedge clk) disable iff (rst)
        (!auto_en && !sw_start) |=> !conv_start);

    a_r2_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (auto_en && trig_sel >= 4'd14 && !sw_start) |=> !conv_start);

    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !locked && !rd_lo) |=>
            (res_lo == $past(conv_result[7:0]) && res_hi == 8'($past(conv_result) >> 8)));

    a_r11_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(res_lo) && $stable(res_hi)));

    a_r12_release: assert property (@(posedge clk) disable iff (rst)
        (locked && rd_hi) |=> !locked);
endmodule

bind adc_trig_ctrl adc_trig_checker #(.RW(RW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .auto_en     (auto_en),
    .sw_start    (sw_start),
    .trig_sel    (trig_sel),
    .conv_busy   (conv_busy),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .rd_lo       (rd_lo),
    .rd_hi       (rd_hi),
    .conv_start  (conv_start),
    .res_lo      (res_lo),
    .res_hi      (res_hi),
    .locked      (res_locked)
);

// File: tb/tb_adc_trig_ctrl.sv
module tb_adc_trig_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        auto_en;
    logic [3:0]  trig_sel;
    logic [15:0] trig_lines;
    logic        sw_start;
    logic        conv_start;
    logic        conv_busy;
    logic        conv_done;
    logic [9:0]  conv_result;
    logic        rd_lo;
    logic        rd_hi;
    logic [7:0]  res_lo;
    logic [7:0]  res_hi;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_trig_ctrl dut (
        .clk(clk), .rst(rst), .auto_en(auto_en), .trig_sel(trig_sel),
        .trig_lines(trig_lines), .sw_start(sw_start), .conv_start(conv_start),
        .conv_busy(conv_busy), .conv_done(conv_done), .conv_result(conv_result),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .res_lo(res_lo), .res_hi(res_hi)
    );

    typedef struct packed {
        logic [3:0] code;
        logic       start;
    } vec_t;

    localparam vec_t VEC [16] = '{
        '{4'd0, 1'b1}, '{4'd1, 1'b1}, '{4'd2, 1'b1}, '{4'd3, 1'b1},
        '{4'd4, 1'b1}, '{4'd5, 1'b1}, '{4'd6, 1'b1}, '{4'd7, 1'b1},
        '{4'd8, 1'b1}, '{4'd9, 1'b1}, '{4'd10, 1'b1}, '{4'd11, 1'b1},
        '{4'd12, 1'b1}, '{4'd13, 1'b1}, '{4'd14, 1'b0}, '{4'd15, 1'b0}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        auto_en = 1'b0; trig_lines = '0; sw_start = 1'b0;
        conv_busy = 1'b0; conv_done = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        trig_sel = '0; conv_result = '0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 res_lo", 16'(res_lo), 16'h00);
        chk("R1 res_hi", 16'(res_hi), 16'h00);
        chk("R1 conv_start", 16'(conv_start), 16'h0);

        // Vector table: R2 code map, R4 flag edge, R7 sync, R8 free-run, R9 width
        for (int v = 0; v < 16; v++) begin
            auto_en = 1'b0; trig_lines = '0; trig_sel = VEC[v].code;
            tick(); tick();
            auto_en = 1'b1;
            trig_lines[VEC[v].code] = 1'b1;
            tick();
            chk($sformatf("R2/R4 start code %0d", VEC[v].code), 16'(conv_start), 16'(VEC[v].start));
            auto_en = 1'b0; trig_lines = '0;
            tick();
            chk($sformatf("R9 one-wide code %0d", VEC[v].code), 16'(conv_start), 16'h0);
        end

        // R3: lines ignored with auto off; software start works
        idle_inputs(); trig_sel = 4'd3;
        tick();
        trig_lines[3] = 1'b1;
        tick();
        chk("R3 line ignored", 16'(conv_start), 16'h0);
        trig_lines = '0; sw_start = 1'b1;
        tick();
        chk("R3 sw start", 16'(conv_start), 16'h1);
        sw_start = 1'b0;
        tick();
        chk("R9 sw start one-wide", 16'(conv_start), 16'h0);

        // R5: already-high flag on enable and on select change
        idle_inputs(); trig_sel = 4'd5; trig_lines[5] = 1'b1;
        tick(); tick();
        auto_en = 1'b1;
        tick();
        chk("R5 enable with high flag", 16'(conv_start), 16'h0);
        tick();
        chk("R5 enable with high flag later", 16'(conv_start), 16'h0);
        trig_lines[6] = 1'b1;
        tick();
        chk("R5 unselected rise", 16'(conv_start), 16'h0);
        trig_sel = 4'd6;
        tick();
        chk("R5 select change to high flag", 16'(conv_start), 16'h0);

        // R6: flag rise while busy is dropped, not queued
        idle_inputs(); trig_sel = 4'd3;
        tick();
        conv_busy = 1'b1; auto_en = 1'b1;
        tick();
        trig_lines[3] = 1'b1;
        tick();
        chk("R6 rise while busy", 16'(conv_start), 16'h0);
        conv_busy = 1'b0;
        tick();
        chk("R6 not queued", 16'(conv_start), 16'h0);
        tick();
        chk("R6 not queued later", 16'(conv_start), 16'h0);

        // R7: sync event while busy vs idle
        idle_inputs(); trig_sel = 4'd0;
        tick();
        conv_busy = 1'b1; auto_en = 1'b1; trig_lines[0] = 1'b1;
        tick();
        chk("R7 sync while busy", 16'(conv_start), 16'h0);
        trig_lines[0] = 1'b0;
        tick();
        conv_busy = 1'b0;
        tick();
        chk("R7 no late start", 16'(conv_start), 16'h0);
        trig_lines[0] = 1'b1;
        tick();
        chk("R7 sync when idle", 16'(conv_start), 16'h1);
        trig_lines[0] = 1'b0;
        tick();

        // R8 free-running with R10 result load
        idle_inputs(); trig_sel = 4'd13;
        tick();
        auto_en = 1'b1;
        tick();
        chk("R8 first start", 16'(conv_start), 16'h1);
        conv_busy = 1'b1;
        tick();
        chk("R9 no start while busy", 16'(conv_start), 16'h0);
        tick();
        chk("R8 busy holds off", 16'(conv_start), 16'h0);
        conv_done = 1'b1; conv_result = 10'h2A5;
        tick();
        chk("R10 low byte", 16'(res_lo), 16'h00A5);
        chk("R10 high byte", 16'(res_hi), 16'h0002);
        chk("R8 no start on done cycle", 16'(conv_start), 16'h0);
        conv_done = 1'b0; conv_busy = 1'b0;
        tick();
        chk("R8 restart after busy falls", 16'(conv_start), 16'h1);
        auto_en = 1'b0; conv_busy = 1'b1;
        tick();
        conv_busy = 1'b0;
        tick();

        // R11 / R12: lock, pending, newest wins, release timing
        idle_inputs();
        rd_lo = 1'b1; conv_done = 1'b1; conv_result = 10'h155;
        tick();
        chk("R11 done on read cycle", 16'(res_lo), 16'h00A5);
        rd_lo = 1'b0; conv_result = 10'h0FF;
        tick();
        chk("R11 locked low", 16'(res_lo), 16'h00A5);
        chk("R11 locked high", 16'(res_hi), 16'h0002);
        conv_result = 10'h3C7;
        tick();
        conv_done = 1'b0;
        tick();
        chk("R11 still locked", 16'(res_lo), 16'h00A5);
        rd_hi = 1'b1;
        tick();
        chk("R12 not yet released", 16'(res_lo), 16'h00A5);
        rd_hi = 1'b0;
        tick();
        chk("R12 newest low", 16'(res_lo), 16'h00C7);
        chk("R12 newest high", 16'(res_hi), 16'h0003);

        // R10 unlocked load with rd_hi but no lock; R1 reset clears
        conv_done = 1'b1; conv_result = 10'h12E; rd_hi = 1'b1;
        tick();
        conv_done = 1'b0; rd_hi = 1'b0;
        chk("R10 unlocked load low", 16'(res_lo), 16'h002E);
        chk("R10 unlocked load high", 16'(res_hi), 16'h0001);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset clears low", 16'(res_lo), 16'h00);
        chk("R1 reset clears high", 16'(res_hi), 16'h00);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule